// File: doc/BRIEF.md
# Pipeline-Status Trace Stream Decoder

This block turns a stream of trace words, one per cycle, into an instruction-address view of the traced processor. Each word carries a 3-bit pipeline status, a 16-bit packet field and a sync flag. For every word accepted the decoder reports the real pipeline status of that cycle, whether the cycle was a trigger, the address of the executed instruction stream and how many low address bits are known from branch packets.

Branch targets arrive as a chain of byte packets that follow the branch cycle. Each byte gives seven address bits and a continuation bit. The packet field holds two bytes per word, and the low byte is consumed before the high byte. The decoder collects these bytes in a small state machine and merges the rebuilt bits into the running address. Between branches the address advances by one instruction step for each executing cycle. A stream end marker closes a pending search and flags it as incomplete.

The gather machine has three states. `S_IDLE`: no branch is pending. `S_HUNT`: a branch was seen and the decoder waits for a synchronised packet word. `S_GATHER`: bytes are being collected. The transitions are: branch (any state) to `S_HUNT`; `S_HUNT` to `S_GATHER` when a synchronised word does not end the chain; `S_HUNT` or `S_GATHER` to `S_IDLE` when the chain completes; any pending state to `S_IDLE` on a stream end, which raises the incomplete flag.

Top module: `pstrace_decoder`

## Requirements
- R1: Bits 2:0 of an input word are the status, bits 18:3 are the packet field and bit 19 is the sync flag. The outputs for a word accepted with `in_valid` high appear at the next rising clock edge with `out_valid` high. A cycle with `in_valid` low sets `out_valid` low and leaves the address and the bit count unchanged.
- R2: Raw status 6 marks a trigger. `out_trigger` is 1, and `out_status` is packet bits 2:0. For any other raw status, `out_trigger` is 0 and `out_status` equals the raw status.
- R3: The address rises by 4 for each word whose real status has low two bits different from 3. Real statuses 3 (wait) and 7 (trace disabled) leave the address unchanged. The rule does not apply to a word that completes a branch address (see R6).
- R4: A real status of 4 or 5 (branch) starts an address search at the next word. While searching, a word supplies bytes only if its sync bit is 1 and its raw status is neither 6 nor 7. Words before such a word are skipped.
- R5: Packet bytes are taken from bits 7:0 first and then bits 15:8. Byte index k places its bits 6:0 at address bit 7k. A byte with bit 7 set asks for another byte. The chain ends on a byte with bit 7 clear, or at the fifth byte, whatever that byte's bit 7 holds. Bytes in a word after the ending byte are unused.
- R6: When a chain of n bytes ends, the low min(7n,32) bits of the address are replaced by the rebuilt bits. The higher bits are kept, no step of 4 is applied for that word, and `out_addr_load` pulses.
- R7: `out_addr_bits` becomes the larger of its previous value and min(7n,32). It never decreases and never exceeds 32.
- R8: Once bytes are being gathered, words whose raw status is 6 or 7 supply no bytes. The chain continues with later words, whatever their sync bit holds.
- R9: A branch status that arrives while a search or gather is pending discards the pending chain and restarts the search at the next word.
- R10: If the word carrying `in_last` leaves a search or gather pending, `out_incomplete` pulses and the search is abandoned. Later words supply no bytes until a new branch arrives.
- R11: After a synchronous active-high reset, `out_valid`, `out_trigger`, `out_addr_load` and `out_incomplete` are 0. `out_addr`, `out_addr_bits` and `out_status` are also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A trace word is presented this cycle |
| in_last | input | 1 | The presented word is the last of the stream |
| in_word | input | 20 | Trace word: status, packet field, sync flag |
| out_valid | output | 1 | Outputs below describe the word from the previous cycle |
| out_status | output | 3 | Real pipeline status of that word |
| out_trigger | output | 1 | That word was a trigger cycle |
| out_addr | output | 32 | Current instruction address |
| out_addr_bits | output | 6 | Count of low address bits known from branch packets |
| out_addr_load | output | 1 | A branch address was completed by that word |
| out_incomplete | output | 1 | The stream ended with a branch address still pending |

## Verification
The embedded properties check the following on every cycle:
- the trigger substitution of the status;
- the step of 4 for executing cycles;
- that the known-bit count only grows and stays capped;
- that the gather count stays inside its bound while gathering;
- that any branch forces a fresh search.

Some outcomes come only from ordered word sequences, so only the bench scenarios can show them. These are the exact rebuilt address after partial-bit merging, the skipping of unsynchronised words, the five-byte cut-off with truncation above bit 31, the discarding of back-to-back branches, and the incomplete flag at stream end.

// File: rtl/pst_pkg.sv
package pst_pkg;

    localparam int CHUNK_W  = 7;
    localparam int STATUS_W = 3;

    typedef enum logic [2:0] {
        PS_EXEC      = 3'd0,
        PS_EXEC_DATA = 3'd1,
        PS_SKIPPED   = 3'd2,
        PS_WAIT      = 3'd3,
        PS_BRANCH    = 3'd4,
        PS_BRANCH_D  = 3'd5,
        PS_TRIGGER   = 3'd6,
        PS_OFF       = 3'd7
    } pstat_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_HUNT   = 2'd1,
        S_GATHER = 2'd2
    } gstate_e;

endpackage

// File: rtl/pst_classify.sv
module pst_classify
    import pst_pkg::*;
#(
    parameter int PKT_W = 16
) (
    input  logic [PKT_W+3:0]    word,
    output logic [STATUS_W-1:0] real_st,
    output logic                trig,
    output logic                sync,
    output logic [PKT_W-1:0]    pkt,
    output logic                pkt_ok,
    output logic                executed,
    output logic                is_branch
);
    logic [STATUS_W-1:0] raw_st;

    always_comb begin
        raw_st = word[STATUS_W-1:0];
        pkt    = word[PKT_W+STATUS_W-1:STATUS_W];
        sync   = word[PKT_W+STATUS_W];
        trig   = (raw_st == PS_TRIGGER);
        // A trigger displaces the true status into the packet field.
        real_st   = trig ? pkt[STATUS_W-1:0] : raw_st;
        pkt_ok    = (raw_st != PS_TRIGGER) && (raw_st != PS_OFF);
        executed  = (real_st[1:0] != 2'b11);
        is_branch = (real_st == PS_BRANCH) || (real_st == PS_BRANCH_D);
    end

endmodule

// File: rtl/pst_gather.sv
module pst_gather
    import pst_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PKT_W     = 16,
    parameter int MAX_BYTES = 5
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 in_valid,
    input  logic                                 in_last,
    input  logic                                 is_branch,
    input  logic                                 sync,
    input  logic                                 pkt_ok,
    input  logic [PKT_W-1:0]                     pkt,
    output logic                                 done,
    output logic [$clog2(MAX_BYTES+1)-1:0]       done_cnt,
    output logic [ADDR_W-1:0]                    done_acc,
    output logic                                 incomplete
);
    localparam int LANES = PKT_W / 8;
    localparam int ACC_W = MAX_BYTES * CHUNK_W;
    localparam int CNT_W = $clog2(MAX_BYTES + 1);

    gstate_e            st_q, st_n;
    logic [CNT_W-1:0]   cnt_q, cnt_n;
    logic [ACC_W-1:0]   acc_q, acc_n;
    logic               take;
    logic               stop;
    int                 n;
    logic [7:0]         lane_b;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
            acc_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            acc_q <= acc_n;
        end
    end

    // Next state and completion outputs
    always_comb begin
        st_n       = st_q;
        cnt_n      = cnt_q;
        acc_n      = acc_q;
        done       = 1'b0;
        done_cnt   = '0;
        incomplete = 1'b0;
        stop       = 1'b0;
        n          = int'(cnt_q);
        lane_b     = '0;

        unique case (st_q)
            S_IDLE:   take = 1'b0;
            S_HUNT:   take = sync && pkt_ok;
            S_GATHER: take = pkt_ok;
            default:  take = 1'b0;
        endcase

        if (in_valid) begin
            if (is_branch) begin
                st_n  = S_HUNT;
                cnt_n = '0;
                acc_n = '0;
            end else if (take) begin
                for (int l = 0; l < LANES; l++) begin
                    if (!stop) begin
                        lane_b = pkt[8*l +: 8];
                        acc_n  = acc_n | (ACC_W'(lane_b[CHUNK_W-1:0]) << (CHUNK_W * n));
                        n      = n + 1;
                        if (!lane_b[7] || n == MAX_BYTES)
                            stop = 1'b1;
                    end
                end
                if (stop) begin
                    done     = 1'b1;
                    done_cnt = CNT_W'(n);
                    st_n     = S_IDLE;
                    cnt_n    = '0;
                end else begin
                    st_n  = S_GATHER;
                    cnt_n = CNT_W'(n);
                end
            end
            if (in_last && st_n != S_IDLE) begin
                incomplete = 1'b1;
                st_n       = S_IDLE;
                cnt_n      = '0;
            end
        end
        done_acc = acc_n[ADDR_W-1:0];
    end

    a_r5_gather_count: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_GATHER) |-> (cnt_q != '0 && int'(cnt_q) < MAX_BYTES));

    a_r9_branch_restart: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_branch && !in_last) |=> (st_q == S_HUNT && cnt_q == '0));

endmodule

// File: rtl/pst_addr_track.sv
module pst_addr_track
    import pst_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_BYTES = 5,
    parameter int ADDR_STEP = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               in_valid,
    input  logic [STATUS_W-1:0]                real_st,
    input  logic                               trig,
    input  logic                               executed,
    input  logic                               done,
    input  logic [$clog2(MAX_BYTES+1)-1:0]     done_cnt,
    input  logic [ADDR_W-1:0]                  done_acc,
    input  logic                               incomplete,
    output logic                               out_valid,
    output logic [STATUS_W-1:0]                out_status,
    output logic                               out_trigger,
    output logic [ADDR_W-1:0]                  out_addr,
    output logic [$clog2(ADDR_W+1)-1:0]        out_addr_bits,
    output logic                               out_addr_load,
    output logic                               out_incomplete
);
    localparam int BITS_W = $clog2(ADDR_W + 1);

    logic [ADDR_W-1:0] addr_q, addr_n, keep_mask;
    logic [BITS_W-1:0] bits_q, bits_n, got_bits;
    int                raw_bits;

    always_comb begin
        raw_bits = CHUNK_W * int'(done_cnt);
        got_bits = (raw_bits >= ADDR_W) ? BITS_W'(ADDR_W) : BITS_W'(raw_bits);
        if (raw_bits >= ADDR_W) keep_mask = '0;
        else                    keep_mask = ~((ADDR_W'(1) << raw_bits) - ADDR_W'(1));
        addr_n = addr_q;
        bits_n = bits_q;
        if (in_valid) begin
            if (done) begin
                addr_n = (addr_q & keep_mask) | (done_acc & ~keep_mask);
                bits_n = (got_bits > bits_q) ? got_bits : bits_q;
            end else if (executed) begin
                addr_n = addr_q + ADDR_W'(ADDR_STEP);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q         <= '0;
            bits_q         <= '0;
            out_valid      <= 1'b0;
            out_status     <= '0;
            out_trigger    <= 1'b0;
            out_addr_load  <= 1'b0;
            out_incomplete <= 1'b0;
        end else begin
            addr_q         <= addr_n;
            bits_q         <= bits_n;
            out_valid      <= in_valid;
            out_trigger    <= in_valid && trig;
            out_addr_load  <= in_valid && done;
            out_incomplete <= in_valid && incomplete;
            if (in_valid)
                out_status <= real_st;
        end
    end

    assign out_addr      = addr_q;
    assign out_addr_bits = bits_q;

    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (in_valid && executed && !done) |=> (addr_q == $past(addr_q) + ADDR_W'(ADDR_STEP)));

    a_r7_bits_grow: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (bits_q >= $past(bits_q)));

    a_r7_bits_cap: assert property (@(posedge clk) disable iff (rst)
        int'(bits_q) <= ADDR_W);

endmodule

// File: rtl/pstrace_decoder.sv
module pstrace_decoder
    import pst_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PKT_W     = 16,
    parameter int MAX_BYTES = 5,
    parameter int ADDR_STEP = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic                          in_last,
    input  logic [PKT_W+3:0]              in_word,
    output logic                          out_valid,
    output logic [2:0]                    out_status,
    output logic                          out_trigger,
    output logic [ADDR_W-1:0]             out_addr,
    output logic [$clog2(ADDR_W+1)-1:0]   out_addr_bits,
    output logic                          out_addr_load,
    output logic                          out_incomplete
);
    localparam int CNT_W = $clog2(MAX_BYTES + 1);

    logic [STATUS_W-1:0] real_st;
    logic                trig, sync, pkt_ok, executed, is_branch;
    logic [PKT_W-1:0]    pkt;
    logic                done, incomplete;
    logic [CNT_W-1:0]    done_cnt;
    logic [ADDR_W-1:0]   done_acc;

    pst_classify #(.PKT_W(PKT_W)) u_cls (
        .word      (in_word),
        .real_st   (real_st),
        .trig      (trig),
        .sync      (sync),
        .pkt       (pkt),
        .pkt_ok    (pkt_ok),
        .executed  (executed),
        .is_branch (is_branch)
    );

    pst_gather #(.ADDR_W(ADDR_W), .PKT_W(PKT_W), .MAX_BYTES(MAX_BYTES)) u_gat (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .is_branch  (is_branch),
        .sync       (sync),
        .pkt_ok     (pkt_ok),
        .pkt        (pkt),
        .done       (done),
        .done_cnt   (done_cnt),
        .done_acc   (done_acc),
        .incomplete (incomplete)
    );

    pst_addr_track #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES), .ADDR_STEP(ADDR_STEP)) u_trk (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (in_valid),
        .real_st        (real_st),
        .trig           (trig),
        .executed       (executed),
        .done           (done),
        .done_cnt       (done_cnt),
        .done_acc       (done_acc),
        .incomplete     (incomplete),
        .out_valid      (out_valid),
        .out_status     (out_status),
        .out_trigger    (out_trigger),
        .out_addr       (out_addr),
        .out_addr_bits  (out_addr_bits),
        .out_addr_load  (out_addr_load),
        .out_incomplete (out_incomplete)
    );

    a_r2_trigger_status: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[2:0] == 3'd6) |=> (out_trigger && out_status == $past(in_word[5:3])));

    a_r10_end_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(out_addr_load && out_incomplete));

endmodule

// File: tb/sim_pstrace_decoder.sv
module sim_pstrace_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 23;

    typedef struct packed {
        logic        v;
        logic        last;
        logic [19:0] word;
        logic [2:0]  st;
        logic        tr;
        logic [31:0] addr;
        logic [5:0]  bits;
        logic        ld;
        logic        inc;
    } vec_t;

    // word = {sync, packet[15:0], status[2:0]}
    localparam vec_t TBL [NVEC] = '{
        '{1'b1,1'b0,20'h00000,3'd0,1'b0,32'h00000004,6'd0, 1'b0,1'b0},
        '{1'b1,1'b0,20'h00003,3'd3,1'b0,32'h00000004,6'd0, 1'b0,1'b0},
        '{1'b1,1'b0,20'h00007,3'd7,1'b0,32'h00000004,6'd0, 1'b0,1'b0},
        '{1'b1,1'b0,20'h00002,3'd2,1'b0,32'h00000008,6'd0, 1'b0,1'b0},
        '{1'b1,1'b0,20'h0000E,3'd1,1'b1,32'h0000000C,6'd0, 1'b0,1'b0},
        '{1'b1,1'b0,20'h00004,3'd4,1'b0,32'h00000010,6'd0, 1'b0,1'b0},
        '{1'b1,1'b0,20'h00408,3'd0,1'b0,32'h00000014,6'd0, 1'b0,1'b0},
        '{1'b1,1'b0,20'h89428,3'd0,1'b0,32'h00000905,6'd14,1'b1,1'b0},
        '{1'b1,1'b0,20'h00001,3'd1,1'b0,32'h00000909,6'd14,1'b0,1'b0},
        '{1'b1,1'b0,20'h00005,3'd5,1'b0,32'h0000090D,6'd14,1'b0,1'b0},
        '{1'b1,1'b0,20'h00004,3'd4,1'b0,32'h00000911,6'd14,1'b0,1'b0},
        '{1'b1,1'b0,20'hC07FA,3'd2,1'b0,32'h00000915,6'd14,1'b0,1'b0},
        '{1'b1,1'b0,20'h0001E,3'd3,1'b1,32'h00000915,6'd14,1'b0,1'b0},
        '{1'b1,1'b0,20'h40C0F,3'd7,1'b0,32'h00000915,6'd14,1'b0,1'b0},
        '{1'b1,1'b0,20'h4540B,3'd3,1'b0,32'h00000915,6'd14,1'b0,1'b0},
        '{1'b1,1'b0,20'h007F8,3'd0,1'b0,32'hF140407F,6'd32,1'b1,1'b0},
        '{1'b1,1'b0,20'h00000,3'd0,1'b0,32'hF1404083,6'd32,1'b0,1'b0},
        '{1'b1,1'b0,20'h00004,3'd4,1'b0,32'hF1404087,6'd32,1'b0,1'b0},
        '{1'b1,1'b0,20'h80018,3'd0,1'b0,32'hF1404083,6'd32,1'b1,1'b0},
        '{1'b0,1'b0,20'h00000,3'd0,1'b0,32'hF1404083,6'd32,1'b0,1'b0},
        '{1'b1,1'b0,20'h00004,3'd4,1'b0,32'hF1404087,6'd32,1'b0,1'b0},
        '{1'b1,1'b1,20'h00001,3'd1,1'b0,32'hF140408B,6'd32,1'b0,1'b1},
        '{1'b1,1'b0,20'h80028,3'd0,1'b0,32'hF140408F,6'd32,1'b0,1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic [19:0] in_word = '0;
    logic        out_valid, out_trigger, out_addr_load, out_incomplete;
    logic [2:0]  out_status;
    logic [31:0] out_addr;
    logic [5:0]  out_addr_bits;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pstrace_decoder u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last), .in_word(in_word),
        .out_valid(out_valid), .out_status(out_status), .out_trigger(out_trigger),
        .out_addr(out_addr), .out_addr_bits(out_addr_bits),
        .out_addr_load(out_addr_load), .out_incomplete(out_incomplete)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // drive after a falling edge, sample at the next falling edge
    task automatic step(input logic v, input logic l, input logic [19:0] w);
        in_valid = v; in_last = l; in_word = w;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 valid", 32'(out_valid), 32'd0);
        chk("R11 addr", out_addr, 32'd0);
        chk("R11 bits", 32'(out_addr_bits), 32'd0);
        chk("R11 pulses", {29'd0, out_trigger, out_addr_load, out_incomplete}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // Table: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NVEC; i++) begin
            step(TBL[i].v, TBL[i].last, TBL[i].word);
            chk($sformatf("R1 valid v%0d", i), 32'(out_valid), 32'(TBL[i].v));
            chk($sformatf("R3/R6 addr v%0d", i), out_addr, TBL[i].addr);
            chk($sformatf("R7 bits v%0d", i), 32'(out_addr_bits), 32'(TBL[i].bits));
            chk($sformatf("R5/R6 load v%0d", i), 32'(out_addr_load), 32'(TBL[i].ld));
            chk($sformatf("R10 incomplete v%0d", i), 32'(out_incomplete), 32'(TBL[i].inc));
            if (TBL[i].v) begin
                chk($sformatf("R2 status v%0d", i), 32'(out_status), 32'(TBL[i].st));
                chk($sformatf("R2 trigger v%0d", i), 32'(out_trigger), 32'(TBL[i].tr));
            end
        end

        // R11 reset mid-stream
        rst = 1'b1;
        @(negedge clk);
        chk("R11 addr after reset", out_addr, 32'd0);
        chk("R11 bits after reset", 32'(out_addr_bits), 32'd0);
        rst = 1'b0;

        // R2 trigger carrying a branch as real status starts a search (R4)
        step(1'b1, 1'b0, 20'h00026);
        chk("R2 trig branch status", 32'(out_status), 32'd4);
        chk("R2 trig flag", 32'(out_trigger), 32'd1);
        chk("R3 trig branch step", out_addr, 32'd4);
        // one-byte chain: low 7 bits replaced, bits 7
        step(1'b1, 1'b0, 20'h80010);
        chk("R6 one-byte load", out_addr, 32'd2);
        chk("R7 first bits", 32'(out_addr_bits), 32'd7);
        chk("R6 load pulse", 32'(out_addr_load), 32'd1);
        // R4/R8: branch, then synced trigger word gives no bytes
        step(1'b1, 1'b0, 20'h00004);
        chk("R3 branch step", out_addr, 32'd6);
        step(1'b1, 1'b0, 20'hBF81E);
        chk("R8 trigger no bytes", 32'(out_addr_load), 32'd0);
        chk("R3 wait via trigger holds", out_addr, 32'd6);
        // R4 unsynced word during hunt: skipped
        step(1'b1, 1'b0, 20'h00028);
        chk("R4 unsynced skipped", 32'(out_addr_load), 32'd0);
        chk("R4 unsynced step", out_addr, 32'd10);
        // R4 synced word: chunk 0x01
        step(1'b1, 1'b0, 20'h80008);
        chk("R4 synced load", 32'(out_addr_load), 32'd1);
        chk("R4 synced addr", out_addr, 32'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule